// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks atomic reservations and locked read-modify-write sequences for one requester port of a cache controller. Completed write-class operations arrive one per cycle, each carrying an operation code, a line address and a requester ID. A load-linked sets a reservation on a line. A later store-conditional succeeds only while that reservation still stands for the same requester. Any store-conditional to the reserved line removes the reservation. A plain store from the owning requester also removes it, and so does an external invalidate that hits the line.

The block also tags each completion with the request class it is forwarded as downstream. Load-linked and store-conditional go out as the atomic class. Every other operation goes out as the exclusive store class. A locked read-modify-write read raises a block on its line toward the request queue, and the matching locked write lowers it. A second locked read while a block is active is reported as a protocol error.

Top module: `rsv_monitor`

## Requirements
- R1: An operation with `cpl_op` = 0 (load-linked) records a reservation on `cpl_line` for `cpl_rid`, replacing any earlier reservation.
- R2: An operation with `cpl_op` = 1 (store-conditional) pulses `sc_done` for one cycle, one clock after the operation. `sc_ok` is 1 only if a valid reservation holds the same line and the same requester ID, and 0 otherwise.
- R3: A store-conditional to the reserved line clears the reservation whether it passed or failed. A store-conditional to a different line leaves the reservation in place.
- R4: Operation codes 2 to 7 (plain store 2, read-modify-write read 3, read-modify-write write 4, locked read 5, locked write 6, code 7 handled like a store) clear the reservation only when both line and requester ID match.
- R5: An `inv_valid` whose `inv_line` equals the reserved line clears the reservation. A hit in the same cycle as a store-conditional makes that store-conditional fail. An invalidate to any other line has no effect.
- R6: Each completion yields a one-cycle `fwd_valid` pulse one clock later, with `fwd_line` equal to the operation's line. `fwd_atomic` is 1 for codes 0 and 1 and 0 for all others.
- R7: A locked read (code 5) with no active block sets `blk_active` and `blk_line` from the next cycle on. A locked write (code 6) whose line equals `blk_line` clears the block. A locked write to another line is ignored.
- R8: A locked read while `blk_active` is 1 pulses `proto_err` one clock later and leaves `blk_active` and `blk_line` unchanged.
- R9: While reset is asserted, `sc_done`, `fwd_valid`, `blk_active` and `proto_err` are 0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpl_valid | input | 1 | A completed operation is presented |
| cpl_op | input | 3 | Operation code (see R1 to R7) |
| cpl_line | input | LINE_W | Line address of the operation |
| cpl_rid | input | RID_W | Requester ID of the operation |
| inv_valid | input | 1 | External invalidate strobe |
| inv_line | input | LINE_W | Line address being invalidated |
| sc_done | output | 1 | Store-conditional result is valid |
| sc_ok | output | 1 | 1 means the store-conditional passed, 0 means it failed |
| fwd_valid | output | 1 | Forwarded request is valid |
| fwd_atomic | output | 1 | 1 means atomic class, 0 means exclusive store class |
| fwd_line | output | LINE_W | Line address of the forwarded request |
| blk_active | output | 1 | Request queue block is active |
| blk_line | output | LINE_W | Line that is blocked |
| proto_err | output | 1 | A locked read arrived while a block was already active |

## Verification
Every pulse output (`sc_done`/`sc_ok`, `fwd_valid`/`fwd_atomic`/`fwd_line` and `proto_err`) appears exactly one clock after its operation is sampled. The block state `blk_active`/`blk_line` changes at that same edge. The bench drives each operation on a falling edge and samples on the next falling edge, which lies half a period after the registering edge. A scoreboard queue receives the expected store-conditional result when the operation is driven. A monitor pops that entry on every `sc_done`, so a missing, extra or late result shows up as a mismatch or as an entry left in the queue.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [2:0] {
    OP_LL      = 3'd0,
    OP_SC      = 3'd1,
    OP_ST      = 3'd2,
    OP_RMW_RD  = 3'd3,
    OP_RMW_WR  = 3'd4,
    OP_LOCK_RD = 3'd5,
    OP_LOCK_WR = 3'd6,
    OP_ST_ALT  = 3'd7
  } op_e;
endpackage

// File: rtl/rsv_resv_unit.sv
module rsv_resv_unit
  import rsv_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int RID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  op_e               cpl_op,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic [RID_W-1:0]  cpl_rid,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              sc_done,
  output logic              sc_ok
);
  logic              rv_q, rv_d;
  logic [LINE_W-1:0] rline_q, rline_d;
  logic [RID_W-1:0]  rrid_q, rrid_d;
  logic              done_d, ok_d;
  logic              inv_hit, live, hit_line, hit_own;

  always_comb begin
    inv_hit  = inv_valid && rv_q && (inv_line == rline_q);
    live     = rv_q && !inv_hit;
    hit_line = live && (rline_q == cpl_line);
    hit_own  = hit_line && (rrid_q == cpl_rid);
    rv_d     = live;
    rline_d  = rline_q;
    rrid_d   = rrid_q;
    done_d   = 1'b0;
    ok_d     = 1'b0;
    if (cpl_valid) begin
      unique case (cpl_op)
        OP_LL: begin
          rv_d    = 1'b1;
          rline_d = cpl_line;
          rrid_d  = cpl_rid;
        end
        OP_SC: begin
          done_d = 1'b1;
          ok_d   = hit_own;
          if (hit_line) rv_d = 1'b0;
        end
        default: if (hit_own) rv_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rline_q <= '0;
      rrid_q  <= '0;
      sc_done <= 1'b0;
      sc_ok   <= 1'b0;
    end else begin
      rv_q    <= rv_d;
      sc_done <= done_d;
      sc_ok   <= ok_d;
      if (cpl_valid && cpl_op == OP_LL) begin
        rline_q <= rline_d;
        rrid_q  <= rrid_d;
      end
    end
  end

  p_ll_sets_resv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_op == OP_LL) |=> (rv_q && rline_q == $past(cpl_line) && rrid_q == $past(cpl_rid)));
  p_sc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_op == OP_SC && rv_q && rline_q == cpl_line) |=> !rv_q);
  p_inv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && rv_q && inv_line == rline_q && !(cpl_valid && cpl_op == OP_LL)) |=> !rv_q);
  p_ok_needs_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> sc_done);
endmodule

// File: rtl/rsv_lock_unit.sv
module rsv_lock_unit
  import rsv_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  op_e               cpl_op,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              blk_active,
  output logic [LINE_W-1:0] blk_line,
  output logic              proto_err
);
  logic              act_d, err_d, load_en;

  always_comb begin
    act_d   = blk_active;
    err_d   = 1'b0;
    load_en = 1'b0;
    if (cpl_valid && cpl_op == OP_LOCK_RD) begin
      if (blk_active) err_d = 1'b1;
      else begin
        act_d   = 1'b1;
        load_en = 1'b1;
      end
    end else if (cpl_valid && cpl_op == OP_LOCK_WR && blk_active && cpl_line == blk_line) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_active <= 1'b0;
      blk_line   <= '0;
      proto_err  <= 1'b0;
    end else begin
      blk_active <= act_d;
      proto_err  <= err_d;
      if (load_en) blk_line <= cpl_line;
    end
  end

  p_lock_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_op == OP_LOCK_RD && !blk_active) |=> (blk_active && blk_line == $past(cpl_line)));
  p_double_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_op == OP_LOCK_RD && blk_active) |=> (proto_err && blk_active && $stable(blk_line)));
endmodule

// File: rtl/rsv_fwd_unit.sv
module rsv_fwd_unit
  import rsv_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  op_e               cpl_op,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              fwd_valid,
  output logic              fwd_atomic,
  output logic [LINE_W-1:0] fwd_line
);
  logic atomic_d;

  always_comb atomic_d = (cpl_op == OP_LL) || (cpl_op == OP_SC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_atomic <= 1'b0;
      fwd_line   <= '0;
    end else begin
      fwd_valid <= cpl_valid;
      if (cpl_valid) begin
        fwd_atomic <= atomic_d;
        fwd_line   <= cpl_line;
      end
    end
  end

  p_fwd_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> (fwd_valid && fwd_line == $past(cpl_line)));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int RID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_op,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic [RID_W-1:0]  cpl_rid,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              fwd_valid,
  output logic              fwd_atomic,
  output logic [LINE_W-1:0] fwd_line,
  output logic              blk_active,
  output logic [LINE_W-1:0] blk_line,
  output logic              proto_err
);
  op_e op;
  assign op = op_e'(cpl_op);

  rsv_resv_unit #(.LINE_W(LINE_W), .RID_W(RID_W)) u_resv (
    .clk, .rst_n, .cpl_valid, .cpl_op(op), .cpl_line, .cpl_rid,
    .inv_valid, .inv_line, .sc_done, .sc_ok
  );

  rsv_lock_unit #(.LINE_W(LINE_W)) u_lock (
    .clk, .rst_n, .cpl_valid, .cpl_op(op), .cpl_line,
    .blk_active, .blk_line, .proto_err
  );

  rsv_fwd_unit #(.LINE_W(LINE_W)) u_fwd (
    .clk, .rst_n, .cpl_valid, .cpl_op(op), .cpl_line,
    .fwd_valid, .fwd_atomic, .fwd_line
  );

  p_sc_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(cpl_valid && cpl_op == 3'd1));
endmodule

// File: tb/sim_rsv_monitor.sv
module sim_rsv_monitor;
  localparam int LW = 26;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cpl_valid, inv_valid;
  logic [2:0] cpl_op;
  logic [LW-1:0] cpl_line, inv_line, fwd_line, blk_line;
  logic [RW-1:0] cpl_rid;
  logic sc_done, sc_ok, fwd_valid, fwd_atomic, blk_active, proto_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  rsv_monitor #(.LINE_W(LW), .RID_W(RW)) u0 (.*);

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for store-conditional results (R2)
  always @(negedge clk) begin
    if (rst_n && sc_done) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected sc result actual=%0d expected=none", sc_ok);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (sc_ok !== e) begin
          n_fail++;
          $display("FAIL R2 sc_ok actual=%0d expected=%0d", sc_ok, e);
        end
      end
    end
  end

  task automatic op(input logic [2:0] o, input logic [LW-1:0] l, input logic [RW-1:0] r,
                    input bit exp_sc = 0, input bit iv = 0, input logic [LW-1:0] il = '0);
    @(negedge clk);
    cpl_valid = 1; cpl_op = o; cpl_line = l; cpl_rid = r;
    inv_valid = iv; inv_line = il;
    if (o == 3'd1) exp_q.push_back(exp_sc);
    @(negedge clk);
    chk("R6 fwd_valid", LW'(fwd_valid), 1);
    chk("R6 fwd_atomic", LW'(fwd_atomic), LW'(o <= 3'd1));
    chk("R6 fwd_line", fwd_line, l);
    cpl_valid = 0; inv_valid = 0;
  endtask

  task automatic inval(input logic [LW-1:0] il);
    @(negedge clk);
    inv_valid = 1; inv_line = il;
    @(negedge clk);
    inv_valid = 0;
  endtask

  localparam logic [LW-1:0] A = 26'h0000A40, B = 26'h0000B80, C = 26'h0123C00, D = 26'h0123D00;

  initial begin
    rst_n = 0; cpl_valid = 0; inv_valid = 0; cpl_op = 0; cpl_line = 0; cpl_rid = 0; inv_line = 0;
    repeat (3) @(negedge clk);
    chk("R9 sc_done", LW'(sc_done), 0);
    chk("R9 fwd_valid", LW'(fwd_valid), 0);
    chk("R9 blk_active", LW'(blk_active), 0);
    chk("R9 proto_err", LW'(proto_err), 0);
    rst_n = 1;
    op(3'd1, A, 4'd1, 0);                      // R9: no reservation after reset
    op(3'd0, A, 4'd1); op(3'd1, A, 4'd1, 1);   // R1 R2 pass
    op(3'd1, A, 4'd1, 0);                      // R3 cleared after pass
    op(3'd0, A, 4'd1); op(3'd1, A, 4'd2, 0);   // R2 wrong id
    op(3'd1, A, 4'd1, 0);                      // R3 cleared after fail
    op(3'd0, A, 4'd1); op(3'd2, A, 4'd1); op(3'd1, A, 4'd1, 0);  // R4 own store clears
    op(3'd0, A, 4'd1); op(3'd2, A, 4'd2); op(3'd2, B, 4'd1);
    op(3'd4, A, 4'd3); op(3'd1, A, 4'd1, 1);   // R4 other id / other line keep
    op(3'd0, A, 4'd1); op(3'd3, A, 4'd1); op(3'd1, A, 4'd1, 0);  // R4 rmw read clears
    op(3'd0, A, 4'd1); op(3'd0, B, 4'd1); op(3'd1, A, 4'd1, 0);  // R1 overwrite
    op(3'd1, B, 4'd1, 1);                      // R3 sc to other line left B intact
    op(3'd0, A, 4'd1); inval(B); op(3'd1, A, 4'd1, 1);           // R5 miss ignored
    op(3'd0, A, 4'd1); inval(A); op(3'd1, A, 4'd1, 0);           // R5 hit clears
    op(3'd0, A, 4'd1); op(3'd1, A, 4'd1, 0, 1, A);               // R5 same-cycle
    op(3'd0, A, 4'd5); op(3'd1, A, 4'd5, 1, 1, B);               // R5 same-cycle miss
    // R7 R8 locked sequences
    op(3'd5, C, 4'd1);
    chk("R7 blk_active set", LW'(blk_active), 1);
    chk("R7 blk_line", blk_line, C);
    chk("R8 no err first lock", LW'(proto_err), 0);
    op(3'd5, D, 4'd1);
    chk("R8 proto_err", LW'(proto_err), 1);
    chk("R8 blk_line kept", blk_line, C);
    chk("R8 blk_active kept", LW'(blk_active), 1);
    op(3'd6, D, 4'd1);
    chk("R7 mismatched unlock ignored", LW'(blk_active), 1);
    chk("R8 err one pulse", LW'(proto_err), 0);
    op(3'd6, C, 4'd1);
    chk("R7 unlock", LW'(blk_active), 0);
    op(3'd5, D, 4'd2);
    chk("R7 relock line", blk_line, D);
    op(3'd6, D, 4'd2);
    op(3'd7, A, 4'd1);                          // R6 code 7 store class
    @(negedge clk);
    chk("R2 sc_done pulse ends", LW'(sc_done), 0);
    chk("R6 fwd_valid pulse ends", LW'(fwd_valid), 0);
    chk("R2 scoreboard drained", LW'(exp_q.size()), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule